// File: doc/BRIEF.md
# Single-Precision Result Packer

This block takes a floating-point result held in unpacked form and turns it into a 32-bit single-precision word. The unpacked form has five parts: a two-bit class, a sign, a signed unbiased exponent, a 26-bit mantissa and a sticky bit. The mantissa holds an explicit leading one, 23 fraction bits, a guard bit and a round bit. The block applies one of four rounding directions. It handles NaN, infinity, zero, normal numbers, subnormal results and overflow. Along with the packed word it raises overflow, underflow and inexact flags.

An arithmetic pipeline uses it as its final write-back stage. The caller presents a result with `in_valid` high. One clock later the packed word and its three flags appear together, qualified by `out_valid`. The word and flags then hold until the next valid input. When the biased exponent is zero or negative, the mantissa is shifted right into the subnormal field and then rounded. Any bits shifted out are folded into sticky. An underflow-trap-enable input makes exact subnormal results also raise underflow. Taking the trap itself is left to the surrounding logic.

Top module: `sp_result_packer`

## Requirements
- R1: Class code 3 (NaN) gives the input sign, exponent field 255, fraction = mantissa bits [24:2] taken without rounding, and fraction bit 22 forced to one. All three flags are clear.
- R2: Class code 2 (infinity) gives the sign, exponent field 255 and a zero fraction. All flags are clear.
- R3: Class code 0 (zero) gives the sign bit with every other bit zero. All flags are clear.
- R4: For class code 1 (number), the 24-bit significand is rounded using guard, round and sticky. The rounding mode codes are: 0 nearest with ties to even, 1 toward zero, 2 toward plus infinity, 3 toward minus infinity. Inexact is raised when guard, round or sticky is set. Mode 1 never increments.
- R5: When rounding a normal carries the significand to 2.0, the exponent field goes up by one and the fraction becomes zero.
- R6: When unbiased exponent + 127 is at most 0, the mantissa, leading one included, is shifted right by 1 − (exponent + 127). Bits that leave the low end are ORed into sticky. The result is then rounded, and the exponent field is 0.
- R7: A subnormal that rounds up to 1.0 × 2^−126 is packed with exponent field 1 and fraction 0, and underflow is not raised.
- R8: A subnormal that stays subnormal raises underflow when it is inexact or when `uf_trap_en` is high. Otherwise underflow stays clear.
- R9: A biased exponent of 255 or more after rounding raises both overflow and inexact.
- R10: On overflow, the word is infinity (exponent 255, fraction 0) in these cases: mode 0; mode 2 with a positive sign; mode 3 with a negative sign. In every other case it is exponent 254 with an all-ones fraction. The sign is kept either way.
- R11: `out_valid` follows `in_valid` by exactly one cycle. Word and flags change only after a valid input. Reset clears `out_valid`, the word and the flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Input result is present this cycle |
| in_class | input | 2 | 0 zero, 1 number, 2 infinity, 3 NaN |
| in_sign | input | 1 | Sign of the result |
| in_exp | input | 10 | Signed unbiased exponent |
| in_mant | input | 26 | Leading one, 23 fraction bits, guard, round |
| in_sticky | input | 1 | OR of all bits below round |
| rnd_mode | input | 2 | Rounding direction code |
| uf_trap_en | input | 1 | Underflow trap enabled |
| out_valid | output | 1 | Packed word and flags are valid |
| out_word | output | 32 | Packed single-precision word |
| out_overflow | output | 1 | Overflow flag |
| out_underflow | output | 1 | Underflow flag |
| out_inexact | output | 1 | Inexact flag |

## Verification
Two things can happen in the same cycle: the rounding carry and a change of exponent range. A carry out of an all-ones significand pushes exponent 254 into overflow. In the same way, a carry out of the largest subnormal promotes it to the smallest normal. The bench provokes both with directed all-ones mantissas at exponents 127 and −127 under each rounding mode, and it also reaches them through random exponents around both edges. Each result is judged against a bench model that works out carry, exponent adjustment, overflow choice and underflow suppression on its own.

// File: rtl/sp_pack_pkg.sv
package sp_pack_pkg;

    localparam int FRAC_W   = 23;
    localparam int EXPF_W   = 8;
    localparam int BIAS     = 127;
    localparam int EXP_TOP  = (1 << EXPF_W) - 1;
    localparam int MANT_W   = FRAC_W + 3;
    localparam int SIG_W    = FRAC_W + 1;
    localparam int EXP_IN_W = 10;
    localparam int BEXP_W   = EXP_IN_W + 2;
    localparam int SH_CAP   = MANT_W + 1;
    localparam int SH_W     = $clog2(SH_CAP + 1);
    localparam int WORD_W   = 1 + EXPF_W + FRAC_W;

    typedef enum logic [1:0] {
        CLS_ZERO = 2'd0,
        CLS_NUM  = 2'd1,
        CLS_INF  = 2'd2,
        CLS_NAN  = 2'd3
    } num_class_e;

    typedef enum logic [1:0] {
        RND_NEAR = 2'd0,
        RND_ZERO = 2'd1,
        RND_POS  = 2'd2,
        RND_NEG  = 2'd3
    } rnd_mode_e;

    typedef struct packed {
        logic ovf;
        logic unf;
        logic inx;
    } pack_flags_t;

    typedef struct packed {
        pack_flags_t           flags;
        logic [WORD_W-1:0]     word;
    } pack_result_t;

    function automatic logic round_up(rnd_mode_e mode, logic sign, logic lsb,
                                      logic [1:0] gr, logic sticky);
        logic lost;
        lost = gr[1] | gr[0] | sticky;
        case (mode)
            RND_NEAR: round_up = gr[1] & (gr[0] | sticky | lsb);
            RND_ZERO: round_up = 1'b0;
            RND_POS:  round_up = lost & ~sign;
            default:  round_up = lost & sign;
        endcase
    endfunction

    function automatic logic overflow_to_inf(rnd_mode_e mode, logic sign);
        case (mode)
            RND_NEAR: overflow_to_inf = 1'b1;
            RND_ZERO: overflow_to_inf = 1'b0;
            RND_POS:  overflow_to_inf = ~sign;
            default:  overflow_to_inf = sign;
        endcase
    endfunction

endpackage

// File: rtl/sp_align_shift.sv
module sp_align_shift #(
    parameter int W   = 26,
    parameter int SHW = 5
) (
    input  logic [W-1:0]   mant_i,
    input  logic           sticky_i,
    input  logic [SHW-1:0] shamt_i,
    output logic [W-1:0]   mant_o,
    output logic           sticky_o
);
    logic lost;

    always_comb begin
        lost = 1'b0;
        for (int i = 0; i < W; i++) begin
            if (int'(shamt_i) > i) lost = lost | mant_i[i];
        end
        mant_o   = mant_i >> shamt_i;
        sticky_o = sticky_i | lost;
    end
endmodule

// File: rtl/sp_round_unit.sv
module sp_round_unit
    import sp_pack_pkg::*;
#(
    parameter int SW = 24
) (
    input  logic [SW-1:0] sig_i,
    input  logic [1:0]    gr_i,
    input  logic          sticky_i,
    input  logic          sign_i,
    input  rnd_mode_e     mode_i,
    output logic [SW:0]   sum_o,
    output logic          inc_o,
    output logic          inexact_o
);
    always_comb begin
        inexact_o = (|gr_i) | sticky_i;
        inc_o     = round_up(mode_i, sign_i, sig_i[0], gr_i, sticky_i);
        sum_o     = {1'b0, sig_i} + (SW+1)'(inc_o);
    end
endmodule

// File: rtl/sp_result_packer.sv
module sp_result_packer
    import sp_pack_pkg::*;
(
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       in_valid,
    input  logic [1:0]                 in_class,
    input  logic                       in_sign,
    input  logic signed [EXP_IN_W-1:0] in_exp,
    input  logic [MANT_W-1:0]          in_mant,
    input  logic                       in_sticky,
    input  logic [1:0]                 rnd_mode,
    input  logic                       uf_trap_en,
    output logic                       out_valid,
    output logic [WORD_W-1:0]          out_word,
    output logic                       out_overflow,
    output logic                       out_underflow,
    output logic                       out_inexact
);
    localparam logic signed [BEXP_W-1:0] BIAS_S   = BEXP_W'(BIAS);
    localparam logic signed [BEXP_W-1:0] TOP_S    = BEXP_W'(EXP_TOP);
    localparam logic signed [BEXP_W-1:0] CAP_S    = BEXP_W'(SH_CAP);
    localparam logic [EXPF_W-1:0]        EXP_INF  = EXPF_W'(EXP_TOP);
    localparam logic [EXPF_W-1:0]        EXP_BIG  = EXPF_W'(EXP_TOP - 1);
    localparam logic [FRAC_W-1:0]        QUIET    = FRAC_W'(1) << (FRAC_W - 1);

    num_class_e               cls;
    rnd_mode_e                mode;
    logic signed [BEXP_W-1:0] bexp;
    logic signed [BEXP_W-1:0] sh_raw;
    logic signed [BEXP_W-1:0] efin;
    logic                     is_sub;
    logic [SH_W-1:0]          shamt;
    logic [MANT_W-1:0]        al_mant;
    logic                     al_sticky;
    logic [SIG_W:0]           sum;
    logic                     inc;
    logic                     inexact;
    logic                     carry;
    logic                     promoted;
    logic                     ovf;
    pack_result_t             res_d;
    pack_result_t             res_q;

    assign cls  = num_class_e'(in_class);
    assign mode = rnd_mode_e'(rnd_mode);

    // Biased exponent and subnormal alignment distance
    always_comb begin
        bexp   = BEXP_W'(in_exp) + BIAS_S;
        is_sub = (bexp <= 0);
        sh_raw = BEXP_W'(1) - bexp;
        if (!is_sub)
            shamt = '0;
        else if (sh_raw > CAP_S)
            shamt = SH_W'(SH_CAP);
        else
            shamt = sh_raw[SH_W-1:0];
    end

    sp_align_shift #(.W(MANT_W), .SHW(SH_W)) u_align (
        .mant_i   (in_mant),
        .sticky_i (in_sticky),
        .shamt_i  (shamt),
        .mant_o   (al_mant),
        .sticky_o (al_sticky)
    );

    sp_round_unit #(.SW(SIG_W)) u_round (
        .sig_i     (al_mant[MANT_W-1:2]),
        .gr_i      (al_mant[1:0]),
        .sticky_i  (al_sticky),
        .sign_i    (in_sign),
        .mode_i    (mode),
        .sum_o     (sum),
        .inc_o     (inc),
        .inexact_o (inexact)
    );

    // Exponent adjustment after rounding
    always_comb begin
        carry    = sum[SIG_W];
        promoted = sum[FRAC_W];
        efin     = bexp + BEXP_W'(carry);
        ovf      = !is_sub && (efin >= TOP_S);
    end

    // Result selection per class
    always_comb begin
        res_d = '0;
        case (cls)
            CLS_ZERO: res_d.word = {in_sign, {(WORD_W-1){1'b0}}};
            CLS_INF:  res_d.word = {in_sign, EXP_INF, {FRAC_W{1'b0}}};
            CLS_NAN:  res_d.word = {in_sign, EXP_INF,
                                    in_mant[MANT_W-2:2] | QUIET};
            default: begin
                res_d.flags.inx = inexact;
                if (is_sub) begin
                    res_d.word = {in_sign, EXPF_W'(promoted), sum[FRAC_W-1:0]};
                    res_d.flags.unf = !promoted && (inexact || uf_trap_en);
                end else if (ovf) begin
                    res_d.flags.ovf = 1'b1;
                    res_d.flags.inx = 1'b1;
                    if (overflow_to_inf(mode, in_sign))
                        res_d.word = {in_sign, EXP_INF, {FRAC_W{1'b0}}};
                    else
                        res_d.word = {in_sign, EXP_BIG, {FRAC_W{1'b1}}};
                end else begin
                    res_d.word = {in_sign, efin[EXPF_W-1:0], sum[FRAC_W-1:0]};
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            res_q     <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) res_q <= res_d;
        end
    end

    assign out_word      = res_q.word;
    assign out_overflow  = res_q.flags.ovf;
    assign out_underflow = res_q.flags.unf;
    assign out_inexact   = res_q.flags.inx;

    // Latency and hold
    p_latency_r11: assert property (@(posedge clk) disable iff (rst)
        in_valid |=> out_valid);
    p_idle_r11: assert property (@(posedge clk) disable iff (rst)
        !in_valid |=> (!out_valid && $stable(out_word)));

    // Flag relations at the output
    p_of_nx_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_overflow) |-> out_inexact);
    p_uf_expzero_r8: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_underflow) |-> (out_word[WORD_W-2:FRAC_W] == '0));
    p_of_shape_r10: assert property (@(posedge clk) disable iff (rst)
        (out_valid && out_overflow) |->
            (out_word[WORD_W-2:FRAC_W] == EXP_INF && out_word[FRAC_W-1:0] == '0) ||
            (out_word[WORD_W-2:FRAC_W] == EXP_BIG && &out_word[FRAC_W-1:0]));
    p_nan_quiet_r1: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls == CLS_NAN) |=> (out_word[FRAC_W-1] && !out_overflow));
    p_rz_no_inf_r10: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls == CLS_NUM && mode == RND_ZERO) |=>
            (out_word[WORD_W-2:FRAC_W] != EXP_INF));
    p_lost_bits_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && cls == CLS_NUM && (in_mant[1:0] != 2'b00 || in_sticky)) |=>
            out_inexact);
    p_rz_no_inc_r4: assert property (@(posedge clk) disable iff (rst)
        (in_valid && mode == RND_ZERO) |-> !inc);
endmodule

// File: tb/test_sp_result_packer.sv
module test_sp_result_packer;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [1:0]  in_class = '0;
    logic        in_sign = 1'b0;
    logic signed [9:0] in_exp = '0;
    logic [25:0] in_mant = '0;
    logic        in_sticky = 1'b0;
    logic [1:0]  rnd_mode = '0;
    logic        uf_trap_en = 1'b0;
    logic        out_valid;
    logic [31:0] out_word;
    logic        out_overflow, out_underflow, out_inexact;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    always #4 clk = ~clk;

    sp_result_packer i_sp_result_packer (
        .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
        .in_sign(in_sign), .in_exp(in_exp), .in_mant(in_mant),
        .in_sticky(in_sticky), .rnd_mode(rnd_mode), .uf_trap_en(uf_trap_en),
        .out_valid(out_valid), .out_word(out_word), .out_overflow(out_overflow),
        .out_underflow(out_underflow), .out_inexact(out_inexact)
    );

    function automatic bit decide(int mode, bit s, bit lsb, int gr, bit st);
        bit any = (gr != 0) || st;
        case (mode)
            0: return ((gr & 2) != 0) && (((gr & 1) != 0) || st || lsb);
            1: return 1'b0;
            2: return any && !s;
            default: return any && s;
        endcase
    endfunction

    // Expected {ovf, unf, inx, word}
    function automatic logic [34:0] ref_pack(int cls, bit s, int e, longint m,
                                             bit st, int mode, bit trap);
        longint sgn = s ? 64'h80000000 : 64'h0;
        longint w = 0, v, keep;
        bit of = 0, uf = 0, nx = 0;
        int b, sh, gr;
        case (cls)
            0: w = sgn;
            2: w = sgn | 64'h7F800000;
            3: w = sgn | 64'h7F800000 | ((m >> 2) & 64'h7FFFFF) | 64'h400000;
            default: begin
                b = e + 127;
                v = m;
                if (b <= 0) begin
                    sh = 1 - b;
                    if (sh >= 26) begin
                        st = st | (m != 0);
                        v = 0;
                    end else begin
                        st = st | ((m & ((64'd1 << sh) - 1)) != 0);
                        v = m >> sh;
                    end
                end
                keep = v >> 2;
                gr = int'(v & 3);
                nx = (gr != 0) || st;
                if (decide(mode, s, keep[0], gr, st)) keep = keep + 1;
                if (b <= 0) begin
                    if (keep == 64'h800000) w = sgn | 64'h800000;
                    else begin
                        w = sgn | keep;
                        uf = nx || trap;
                    end
                end else begin
                    if (keep == 64'h1000000) begin
                        b = b + 1;
                        keep = keep >> 1;
                    end
                    if (b >= 255) begin
                        of = 1; nx = 1;
                        if (mode == 0 || (mode == 2 && !s) || (mode == 3 && s))
                            w = sgn | 64'h7F800000;
                        else
                            w = sgn | 64'h7F7FFFFF;
                    end else
                        w = sgn | (longint'(b) << 23) | (keep & 64'h7FFFFF);
                end
            end
        endcase
        return {of, uf, nx, w[31:0]};
    endfunction

    task automatic run_one(int cls, bit s, int e, longint m, bit st, int mode,
                           bit trap, string tag);
        logic [34:0] expv, got;
        @(negedge clk);
        in_valid = 1'b1; in_class = 2'(cls); in_sign = s; in_exp = 10'(e);
        in_mant = 26'(m); in_sticky = st; rnd_mode = 2'(mode); uf_trap_en = trap;
        expv = ref_pack(cls, s, e, m, st, mode, trap);
        @(negedge clk);
        in_valid = 1'b0;
        got = {out_overflow, out_underflow, out_inexact, out_word};
        checks++;
        if (!out_valid || got !== expv) begin
            fails++;
            $display("FAIL %s: cls=%0d e=%0d m=%h mode=%0d got v=%b %h expected v=1 %h",
                     tag, cls, e, m, mode, out_valid, got, expv);
        end
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: run did not end, got hang expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        logic [31:0] held;
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_word !== 32'h0 || out_overflow || out_underflow || out_inexact) begin
            fails++;
            $display("FAIL R11 reset: got %b %h expected 0 00000000", out_valid, out_word);
        end
        rst = 1'b0;

        // Specials
        run_one(0, 0, 0, 0, 0, 0, 0, "R3");
        run_one(0, 1, 5, 26'h3FFFFFF, 1, 2, 1, "R3");
        run_one(2, 1, 0, 0, 0, 1, 0, "R2");
        run_one(3, 0, 0, 26'h2000004, 0, 0, 0, "R1");
        run_one(3, 1, 0, 26'h3FFFFFF, 1, 1, 0, "R1");
        // Normal rounding
        run_one(1, 0, 0, 26'h2000000, 0, 0, 0, "R4");
        run_one(1, 0, 0, 26'h2000002, 0, 0, 0, "R4");
        run_one(1, 0, 0, 26'h2000006, 0, 0, 0, "R4");
        run_one(1, 1, 3, 26'h2000001, 0, 3, 0, "R4");
        run_one(1, 0, 3, 26'h2000003, 1, 1, 0, "R4");
        run_one(1, 0, 0, 26'h3FFFFFF, 0, 0, 0, "R5");
        // Overflow choices
        for (int md = 0; md < 4; md++) begin
            run_one(1, 0, 127, 26'h3FFFFFF, 0, md, 0, "R9");
            run_one(1, 1, 127, 26'h3FFFFFF, 0, md, 0, "R10");
            run_one(1, 1, 200, 26'h2000000, 0, md, 0, "R10");
        end
        // Subnormals
        run_one(1, 0, -127, 26'h2000000, 0, 0, 0, "R8");
        run_one(1, 0, -127, 26'h2000000, 0, 0, 1, "R8");
        run_one(1, 0, -127, 26'h3FFFFFF, 0, 0, 0, "R7");
        run_one(1, 1, -127, 26'h3FFFFFF, 0, 3, 0, "R7");
        run_one(1, 0, -130, 26'h2345679, 0, 0, 0, "R6");
        run_one(1, 0, -200, 26'h2000000, 0, 2, 0, "R6");
        run_one(1, 1, -200, 26'h2000000, 0, 2, 0, "R6");

        // Hold when idle
        run_one(1, 0, 10, 26'h2ABCDEF, 0, 0, 0, "R11");
        held = out_word;
        @(negedge clk);
        in_class = 2'd2; in_mant = 26'h1234567; in_exp = 10'sd50;
        @(negedge clk);
        checks++;
        if (out_valid !== 1'b0 || out_word !== held) begin
            fails++;
            $display("FAIL R11 hold: got %b %h expected 0 %h", out_valid, out_word, held);
        end

        // Random mix
        for (int n = 0; n < 3000; n++) begin
            int r = int'($urandom_range(0, 9));
            int cls = (r == 0) ? 0 : (r == 1) ? 2 : (r == 2) ? 3 : 1;
            int e = int'($urandom_range(0, 305)) - 170;
            longint m = longint'({1'b1, 25'($urandom)});
            bit s = 1'($urandom);
            bit st = 1'($urandom);
            int md = int'($urandom_range(0, 3));
            bit tr = 1'($urandom);
            string tag;
            if (cls == 0) tag = "R3";
            else if (cls == 2) tag = "R2";
            else if (cls == 3) tag = "R1";
            else if (e + 127 <= 0) tag = "R6";
            else if (e >= 127) tag = "R9";
            else tag = "R4";
            run_one(cls, s, e, m, st, md, tr, tag);
        end

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule